// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers a vertical sync signal from a digitised composite sync stream. It does not follow the sync edges. Instead it measures how long each active (low) sync pulse lasts, counted in ticks of a slow reference clock that reaches the block as a clock enable. Horizontal sync and equalization pulses are short, so their count stays below a programmed threshold and they do not produce vertical sync. The long serrated pulses of the vertical interval run past the threshold, and the separated vertical sync output switches on during them.

Software sets the threshold to a value above the widest expected horizontal or equalization pulse. At a 5 MHz tick rate the reset value of 32 ticks corresponds to 6.4 µs. The width of the most recent active pulse, in ticks, is also brought out as a status value. A threshold of zero turns separation off.

Top module: `csync_vsep`

## Requirements
- R1: After synchronous reset, `vsync_o` is 0 and `width_o` is 0.
- R2: `csync_n_i` is active low and passes through a two-stage synchroniser. `width_o` restarts from 0 at each high-to-low transition. It then advances by one for each `tick_en_i` cycle while the input stays low, so that after a pulse of N ticks it reads N, within one tick.
- R3: The width count saturates at 255. Pulses longer than 255 ticks leave `width_o` at 255.
- R4: With a nonzero `thresh_i`, `vsync_o` goes to 1 during an active pulse once the count reaches `thresh_i`. It is then 1 before that pulse ends.
- R5: `vsync_o` returns to 0 only when a later active pulse ends with a count below `thresh_i`. A short pulse therefore never raises it, and it clears it.
- R6: While `thresh_i` is 0, `vsync_o` is 0 from the next clock onward, whatever the pulse widths.
- R7: While `csync_n_i` stays high (inactive), `width_o` holds the width of the last pulse.
- R8: Cycles with `tick_en_i` low do not advance the width count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en_i | input | 1 | Reference-rate clock enable, one cycle per tick |
| csync_n_i | input | 1 | Digitised composite sync, active low, asynchronous |
| thresh_i | input | 8 | Vertical pulse threshold in ticks, 0 disables |
| vsync_o | output | 1 | Separated vertical sync, active high |
| width_o | output | 8 | Width in ticks of the current or last active pulse |

## Verification
On every cycle the assertions check the following. The width status only holds, increments by one or restarts at zero. It never moves on a cycle without a tick. It stays pinned once saturated. Every rise of vertical sync is backed by a count at or above a nonzero threshold, and every fall by a count below it or a zero threshold. What the count means in ticks can only be shown by the bench's pulse scenarios: hsync-length pulses are ignored, long pulses raise vertical sync in mid-pulse, pulses just either side of the threshold are classified correctly, the count saturates at 255, and reprogramming the threshold moves the decision point.

// File: rtl/csync_vsep_pkg.sv
package csync_vsep_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    // Per-cycle view of the synchronised sync level
    typedef struct packed {
        logic active;  // sync currently in its active level
        logic rise;    // first cycle of an active pulse
        logic held;    // active now and in the previous cycle
        logic fall;    // first cycle after an active pulse
    } sync_ev_t;

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == '1) ? v : cnt_t'(v + 1'b1);
    endfunction

endpackage

// File: rtl/csync_vsep_sync.sv
module csync_vsep_sync
    import csync_vsep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     csync_n_i,
    output sync_ev_t ev_o
);

    logic [STAGES-1:0] shreg;
    logic              act_q;
    logic              act;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) shreg <= '1;
                else     shreg <= csync_n_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) shreg <= '1;
                else     shreg <= {shreg[STAGES-2:0], csync_n_i};
            end
        end
    endgenerate

    assign act = ~shreg[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act;
    end

    always_comb begin
        ev_o.active = act;
        ev_o.rise   = act & ~act_q;
        ev_o.held   = act & act_q;
        ev_o.fall   = ~act & act_q;
    end

endmodule

// File: rtl/csync_vsep_width.sv
module csync_vsep_width
    import csync_vsep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en_i,
    input  sync_ev_t ev_i,
    output cnt_t     cnt_o
);

    always_ff @(posedge clk) begin
        if (rst)                        cnt_o <= '0;
        else if (ev_i.rise)             cnt_o <= '0;
        else if (ev_i.held && tick_en_i) cnt_o <= sat_inc(cnt_o);
    end

endmodule

// File: rtl/csync_vsep_decide.sv
module csync_vsep_decide
    import csync_vsep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t ev_i,
    input  cnt_t     cnt_i,
    input  cnt_t     thresh_i,
    output logic     vsync_o
);

    logic off;
    logic long_now;

    assign off      = (thresh_i == '0);
    assign long_now = (cnt_i >= thresh_i);

    always_ff @(posedge clk) begin
        if (rst)                           vsync_o <= 1'b0;
        else if (off)                      vsync_o <= 1'b0;
        else if (ev_i.held && long_now)    vsync_o <= 1'b1;
        else if (ev_i.fall && !long_now)   vsync_o <= 1'b0;
    end

endmodule

// File: rtl/csync_vsep.sv
module csync_vsep
    import csync_vsep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en_i,
    input  logic             csync_n_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             vsync_o,
    output logic [CNT_W-1:0] width_o
);

    sync_ev_t ev;
    cnt_t     cnt;

    csync_vsep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .csync_n_i (csync_n_i),
        .ev_o      (ev)
    );

    csync_vsep_width u_width (
        .clk       (clk),
        .rst       (rst),
        .tick_en_i (tick_en_i),
        .ev_i      (ev),
        .cnt_o     (cnt)
    );

    csync_vsep_decide u_decide (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .cnt_i    (cnt),
        .thresh_i (thresh_i),
        .vsync_o  (vsync_o)
    );

    assign width_o = cnt;

endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk
    import csync_vsep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick_en_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic             vsync_o,
    input logic [CNT_W-1:0] width_o
);

    p_width_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (width_o == $past(width_o)) || (width_o == '0) ||
                 (width_o == cnt_t'($past(width_o) + 1'b1)));

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (width_o == '1) |=> (width_o == '1) || (width_o == '0));

    p_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_o) |-> ($past(thresh_i) != '0) &&
                           ($past(width_o) >= $past(thresh_i)));

    p_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_o) |-> ($past(thresh_i) == '0) ||
                           ($past(width_o) < $past(thresh_i)));

    p_off_r6: assert property (@(posedge clk) disable iff (rst)
        (thresh_i == '0) |=> !vsync_o);

    p_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !tick_en_i |=> (width_o == $past(width_o)) || (width_o == '0));

endmodule

bind csync_vsep csync_vsep_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en_i (tick_en_i),
    .thresh_i  (thresh_i),
    .vsync_o   (vsync_o),
    .width_o   (width_o)
);

// File: tb/csync_vsep_tb_top.sv
`timescale 1ns/1ps
module csync_vsep_tb_top;

    localparam int TDIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       csync_n = 1'b1;
    logic [7:0] thr = 8'h20;
    logic       vsync;
    logic [7:0] width;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  tick_on = 1'b1;
    bit  done = 1'b0;
    int  div = 0;

    typedef struct {
        string req;
        bit    exp_vs;
        int    exp_w;
        bit    chk_w;
    } item_t;

    item_t q[$];
    event  ev_chk;

    always #2 clk = ~clk;

    csync_vsep dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en_i (tick_en),
        .csync_n_i (csync_n),
        .thresh_i  (thr),
        .vsync_o   (vsync),
        .width_o   (width)
    );

    // tick generator, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            tick_en = tick_on && (div == 0);
            div = (div == TDIV - 1) ? 0 : div + 1;
        end
    end

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(ev_chk);
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (vsync !== it.exp_vs) begin
                    n_fail++;
                    $display("FAIL %s vsync actual=%0b expected=%0b", it.req, vsync, it.exp_vs);
                end
                if (it.chk_w) begin
                    int d;
                    n_checks++;
                    d = int'(width) - it.exp_w;
                    if (d > 1 || d < -1) begin
                        n_fail++;
                        $display("FAIL %s width actual=%0d expected=%0d", it.req, width, it.exp_w);
                    end
                end
            end
        end
    end

    task automatic expect_now(string req, bit vs, int w, bit cw);
        item_t it;
        it.req = req; it.exp_vs = vs; it.exp_w = w; it.chk_w = cw;
        q.push_back(it);
        ->ev_chk;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic gap(int ticks);
        csync_n = 1'b1;
        repeat (ticks * TDIV) @(negedge clk);
    endtask

    // active pulse of L ticks; optional mid-pulse vsync check after mid ticks
    task automatic pulse(int L, int mid, string req, bit vs_after);
        int w;
        csync_n = 1'b0;
        if (mid > 0) begin
            repeat (mid * TDIV) @(negedge clk);
            expect_now(req, 1'b1, 0, 1'b0);
            repeat ((L - mid) * TDIV - 2) @(negedge clk);
        end else begin
            repeat (L * TDIV) @(negedge clk);
        end
        csync_n = 1'b1;
        repeat (6) @(negedge clk);
        w = tick_on ? ((L > 255) ? 255 : L) : 0;
        expect_now(req, vs_after, w, 1'b1);
        gap(10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1", 1'b0, 0, 1'b1);

        // threshold 32: hsync-like pulse is ignored
        pulse(20, 0, "R2", 1'b0);
        gap(40);
        expect_now("R7", 1'b0, 20, 1'b1);

        // long pulse raises vsync in mid pulse and keeps it
        pulse(40, 36, "R4", 1'b1);
        // short pulse clears it
        pulse(10, 0, "R5", 1'b0);
        // saturation
        pulse(300, 0, "R3", 1'b1);
        // boundaries around 32
        pulse(34, 0, "R4", 1'b1);
        pulse(30, 0, "R5", 1'b0);

        // disabling
        pulse(50, 0, "R4", 1'b1);
        thr = 8'd0;
        repeat (3) @(negedge clk);
        expect_now("R6", 1'b0, 50, 1'b1);
        pulse(60, 0, "R6", 1'b0);

        // reprogrammed threshold
        thr = 8'd100;
        pulse(60, 0, "R4", 1'b0);
        pulse(120, 0, "R4", 1'b1);
        pulse(98, 0, "R5", 1'b0);

        // no ticks: width stays at zero
        tick_on = 1'b0;
        pulse(20, 0, "R8", 1'b0);
        tick_on = 1'b1;
        gap(2);
        pulse(25, 0, "R2", 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule